// File: doc/BRIEF.md
# Daisy-Chain Crosspoint Serial Loader

This block is a host-side controller that writes a complete routing configuration into a chain of `NDEV` identical 16×16 analog crosspoint devices. The devices share one serial port. Each device's serial output feeds the next device's serial input, and all devices share the clock, chip-enable and update lines. The host presents a routing table and pulses `start`. The table holds, for every output of every device, a 4-bit source input and an enable flag. The loader then produces the device clock, the serial data, chip enable and the update strobe. It raises `done` for one cycle when the new configuration has been applied.

Each device receives 80 bits per pass: 16 output slots of 5 bits each. The whole stream is shifted with update held inactive, so no partial pattern reaches the switch matrix. After the last bit, update is pulsed low once to commit the configuration. The device clock runs at a programmable fraction of the system clock, and the length of the update pulse is also programmable.

A grouping mode routes multi-wire video channels together. Differential pairs and luma/chroma pairs use groups of two. Component video uses groups of three. In these modes one table entry describes one logical route, and the loader expands it into consecutive physical routes inside each device.

Top module: `xbar_chain_loader`

## Requirements
- R1: After reset, and while idle, `busy`=0, `done`=0, `dev_cs_n`=1, `dev_upd_n`=1 and `dev_clk`=1.
- R2: A pass produces exactly 80×`NDEV` falling edges on `dev_clk`. `dev_cs_n` stays low from the start of the pass until `done`.
- R3: Stream order. Bit number b counts from 0, the first bit sent. Bit b belongs to device `NDEV-1-b/80` and to output `15-(b%80)/5` of that device. Within each 5-bit slot the first four bits are the source select, least significant bit first, and the fifth bit is the enable. In direct mode (`group_mode` 0 or 3), table entry e = device×16+output supplies the slot: source from `route_src[4e+3:4e]`, enable from `route_en[e]`. When the enable is 0, the source bits are don't-care.
- R4: `dev_upd_n` is high at every falling edge of `dev_clk`. It goes low only after the last falling edge of the pass.
- R5: `dev_data` changes only while `dev_clk` is high. The high phase and the low phase of `dev_clk` each last `half_period` system cycles; a value of 0 counts as 1. `done` is therefore seen 2×`half_period`×80×`NDEV`+`apply_len`+1 clock edges after the edge that samples `start`, counting that edge as the first.
- R6: `dev_upd_n` stays low for `apply_len` system cycles (0 counts as 1) and then returns high. In the same edge, `done` pulses high for exactly one cycle and `busy` falls. `busy` is high from the cycle after `start` until `done`.
- R7: A `start` pulse that arrives while `busy` is high has no effect: the running pass keeps its length and its bit stream.
- R8: Pair mode (`group_mode`=1). Physical output o of device d uses table entry d×16+o/2. If that entry names source j with enable set, the physical source is 2j+(o%2). The output is disabled when this value exceeds 15.
- R9: Triple mode (`group_mode`=2). Physical output o of device d uses entry d×16+o/3, with physical source 3j+(o%3). The output is disabled when the source exceeds 15 or when o/3 ≥ 5, so output 15 is always disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a pass |
| group_mode | input | 2 | 0/3 direct, 1 pairs, 2 triples |
| half_period | input | CNT_W | System cycles per device-clock phase |
| apply_len | input | CNT_W | System cycles of the update low pulse |
| route_src | input | NDEV*64 | 4-bit source per table entry, entry e at bits 4e+3:4e |
| route_en | input | NDEV*16 | Enable flag per table entry |
| dev_clk | output | 1 | Device shift clock, data captured on its falling edge |
| dev_data | output | 1 | Serial data into the first device of the chain |
| dev_cs_n | output | 1 | Active-low chip enable |
| dev_upd_n | output | 1 | Active-low update strobe |
| busy | output | 1 | Pass in progress |
| done | output | 1 | One-cycle pulse when the configuration is applied |

## Verification
A device-chain model in the bench captures `dev_data` on every falling edge of `dev_clk`. The captured stream is compared bit by bit against a bench-computed map only after `done`, when the whole pass has settled. Per pass, `done` is due 2×`half_period`×80×`NDEV`+`apply_len`+1 edges after `start` is sampled. The bench counts edges to that point, then confirms that `done` has dropped one cycle later. Data stability and the update level at each device-clock fall are sampled between system-clock edges (on the negative edge), so every check reads settled values.

// File: rtl/xbar_chain_loader.sv
module xbar_chain_loader #(
  parameter int NDEV  = 2,
  parameter int CNT_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [1:0]            group_mode,
  input  logic [CNT_W-1:0]      half_period,
  input  logic [CNT_W-1:0]      apply_len,
  input  logic [NDEV*64-1:0]    route_src,
  input  logic [NDEV*16-1:0]    route_en,
  output logic                  dev_clk,
  output logic                  dev_data,
  output logic                  dev_cs_n,
  output logic                  dev_upd_n,
  output logic                  busy,
  output logic                  done
);
  localparam int OUTS  = 16;
  localparam int SLOT  = 5;
  localparam int DBITS = OUTS * SLOT;
  localparam int TOTAL = NDEV * DBITS;
  localparam int BW    = $clog2(TOTAL);

  typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_APPLY} st_t;

  st_t              st;
  logic [BW-1:0]    bitcnt;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] half_m, len_m;
  logic             bit_c;

  assign half_m   = (half_period == '0) ? CNT_W'(1) : half_period;
  assign len_m    = (apply_len == '0) ? CNT_W'(1) : apply_len;
  assign busy     = (st != S_IDLE);
  assign dev_data = bit_c;

  always_comb begin
    int b, d, o, t, g, k, j, s;
    logic [3:0] src;
    logic       en;
    b = int'(bitcnt);
    d = NDEV - 1 - b / DBITS;
    o = OUTS - 1 - (b % DBITS) / SLOT;
    t = b % SLOT;
    g = (group_mode == 2'd1) ? 2 : (group_mode == 2'd2) ? 3 : 1;
    k = o / g;
    j = int'(route_src[(d*OUTS + k)*4 +: 4]);
    s = g * j + o % g;
    en  = route_en[d*OUTS + k] && (k < OUTS / g) && (s < OUTS);
    src = s[3:0];
    bit_c = (t == SLOT - 1) ? en : src[t[1:0]];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      bitcnt    <= '0;
      cnt       <= '0;
      dev_clk   <= 1'b1;
      dev_cs_n  <= 1'b1;
      dev_upd_n <= 1'b1;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          st       <= S_SHIFT;
          bitcnt   <= '0;
          cnt      <= '0;
          dev_clk  <= 1'b1;
          dev_cs_n <= 1'b0;
        end
        S_SHIFT: begin
          if (cnt == half_m - 1'b1) begin
            cnt <= '0;
            if (dev_clk) begin
              dev_clk <= 1'b0;
            end else begin
              dev_clk <= 1'b1;
              if (bitcnt == BW'(TOTAL - 1)) begin
                st        <= S_APPLY;
                dev_upd_n <= 1'b0;
              end else begin
                bitcnt <= bitcnt + 1'b1;
              end
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_APPLY: begin
          if (cnt == len_m - 1'b1) begin
            cnt       <= '0;
            st        <= S_IDLE;
            dev_upd_n <= 1'b1;
            dev_cs_n  <= 1'b1;
            done      <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module xbar_chain_loader_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic dev_clk,
  input logic dev_data,
  input logic dev_cs_n,
  input logic dev_upd_n,
  input logic busy,
  input logic done
);
  assert_cs_during_update_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !dev_upd_n |-> !dev_cs_n);
  assert_update_high_at_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dev_clk) |-> (dev_upd_n && !dev_cs_n));
  assert_data_stable_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !dev_clk |-> $stable(dev_data));
  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_ends_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy) && dev_upd_n));
  assert_idle_levels_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (dev_cs_n && dev_upd_n && dev_clk));
  assert_start_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy && dev_upd_n) |=> busy);
endmodule

bind xbar_chain_loader xbar_chain_loader_chk i_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .dev_clk(dev_clk),
  .dev_data(dev_data), .dev_cs_n(dev_cs_n), .dev_upd_n(dev_upd_n),
  .busy(busy), .done(done)
);

// File: tb/test_xbar_chain_loader.sv
module test_xbar_chain_loader;
  localparam int NDEV  = 2;
  localparam int CNT_W = 8;
  localparam int TOTAL = NDEV * 80;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] group_mode = 2'd0;
  logic [CNT_W-1:0] half_period = 8'd1, apply_len = 8'd1;
  logic [NDEV*64-1:0] route_src = '0;
  logic [NDEV*16-1:0] route_en = '0;
  logic dev_clk, dev_data, dev_cs_n, dev_upd_n, busy, done;

  int checks = 0, fails = 0, cyc = 0;
  int falls = 0, upd_bad = 0, data_bad = 0, upd_low = 0, cs_bad = 0;
  logic [TOTAL-1:0] shreg = '0;
  logic prev_data = 1'b0;

  xbar_chain_loader #(.NDEV(NDEV), .CNT_W(CNT_W)) i_xbar_chain_loader (
    .clk(clk), .rst_n(rst_n), .start(start), .group_mode(group_mode),
    .half_period(half_period), .apply_len(apply_len), .route_src(route_src),
    .route_en(route_en), .dev_clk(dev_clk), .dev_data(dev_data),
    .dev_cs_n(dev_cs_n), .dev_upd_n(dev_upd_n), .busy(busy), .done(done));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge dev_clk) if (rst_n && !dev_cs_n) begin
    shreg = {shreg[TOTAL-2:0], dev_data};
    falls++;
    if (!dev_upd_n) upd_bad++;
  end

  always @(negedge clk) if (rst_n) begin
    if (!dev_clk && dev_data !== prev_data) data_bad++;
    prev_data = dev_data;
    if (!dev_upd_n) upd_low++;
    if (busy && dev_cs_n) cs_bad++;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++; checks++;
      $display("FAIL watchdog: run hung, got %0d cycles expected < 150000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // returns {care, value} for slot bit t of output o of device d
  function automatic logic [1:0] exp_bit(int mode, int d, int o, int t);
    int g, k, j, s;
    logic en;
    logic [3:0] src;
    g = (mode == 1) ? 2 : (mode == 2) ? 3 : 1;
    k = o / g;
    j = int'(route_src[(d*16 + k)*4 +: 4]);
    s = g * j + o % g;
    en = route_en[d*16 + k] && (k < 16 / g) && (s < 16);
    src = s[3:0];
    if (t == 4) return {1'b1, en};
    return {en, src[t[1:0]]};
  endfunction

  task automatic run_pass(input int mode, input int div, input int len,
                          input bit poke, input string req);
    int n, bad, dm, lm;
    logic [1:0] e;
    dm = (div == 0) ? 1 : div;
    lm = (len == 0) ? 1 : len;
    @(negedge clk);
    group_mode = mode[1:0]; half_period = div[7:0]; apply_len = len[7:0];
    falls = 0; upd_bad = 0; data_bad = 0; upd_low = 0; cs_bad = 0;
    start = 1'b1;
    n = 0;
    @(posedge clk); n++;
    @(negedge clk); start = 1'b0;
    while (!done) begin
      if (poke && n == 37) start = 1'b1; else start = 1'b0;
      @(posedge clk); n++;
      @(negedge clk);
    end
    start = 1'b0;
    chk(n == 2*dm*TOTAL + lm + 1, {"R5 cycles to done ", req}, n, 2*dm*TOTAL + lm + 1);
    chk(falls == TOTAL, {"R2 clock falls ", req}, falls, TOTAL);
    chk(cs_bad == 0, {"R2 cs_n high while busy ", req}, cs_bad, 0);
    chk(upd_bad == 0, {"R4 update low at clock fall ", req}, upd_bad, 0);
    chk(data_bad == 0, {"R5 data moved while clock low ", req}, data_bad, 0);
    chk(upd_low == lm, {"R6 update low cycles ", req}, upd_low, lm);
    chk(!busy && dev_upd_n, {"R6 busy/update after done ", req}, {busy, dev_upd_n}, 1);
    bad = 0;
    for (int b = 0; b < TOTAL; b++) begin
      e = exp_bit(mode, NDEV - 1 - b / 80, 15 - (b % 80) / 5, b % 5);
      if (e[1] && shreg[TOTAL-1-b] !== e[0]) bad++;
    end
    chk(bad == 0, {"R3 stream mismatches ", req}, bad, 0);
    @(negedge clk);
    chk(!done, {"R6 done one cycle ", req}, done, 0);
  endtask

  initial begin
    void'($urandom(32'd2024));
    #(3*CLK_PERIOD);
    @(negedge clk);
    chk(!busy && !done && dev_cs_n && dev_upd_n && dev_clk, "R1 reset levels",
        {busy, done, dev_cs_n, dev_upd_n, dev_clk}, 5'b00111);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && dev_cs_n && dev_upd_n && dev_clk, "R1 idle after reset",
        {busy, dev_cs_n, dev_upd_n, dev_clk}, 4'b0111);

    for (int e = 0; e < NDEV*16; e++) begin
      route_src[e*4 +: 4] = 4'(e);
      route_en[e] = 1'b1;
    end
    run_pass(0, 1, 1, 0, "R3 direct ascending");
    run_pass(0, 0, 0, 0, "R5 zero divider and length");
    route_en = {NDEV{16'hA5C3}};
    run_pass(3, 2, 4, 0, "R3 mode3 direct mixed enables");
    for (int e = 0; e < NDEV*16; e++) route_src[e*4 +: 4] = 4'(e % 9);
    route_en = '1;
    run_pass(1, 1, 3, 0, "R8 pair mode with overflow");
    run_pass(2, 2, 2, 0, "R9 triple mode with output 15");
    run_pass(0, 1, 2, 1, "R7 start during pass");
    for (int i = 0; i < 5; i++) begin
      route_src = {$urandom, $urandom, $urandom, $urandom}; 
      route_en  = NDEV*16'($urandom);
      run_pass(int'($urandom % 3), 1 + int'($urandom % 3), int'($urandom % 6), 0,
               i[0] ? "R8 random" : "R9 random");
    end
    @(negedge clk);
    chk(!busy && dev_cs_n && dev_clk, "R1 idle at end", {busy, dev_cs_n, dev_clk}, 3'b011);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule